// File: doc/BRIEF.md
# Packet Stream Conformance Checker

This block sits on the output of a packet traffic generator and confirms that the stream matches what the generator was told to produce. Software, or a test sequencer, writes a set of expectations through a small register write port. These are the number of packets, the packet length, how many header and stamp words open each packet, the burst size, the idle gap expected inside a burst and between bursts, and the word values expected in the header, the stamp and the padding that fills the rest of the packet. A start pulse copies these expectations into working registers, clears all results and arms the checker.

The checker follows each packet word by word. Words are classed as header, stamp or padding from their position after start-of-packet. The packet length is checked at end-of-packet, and the idle cycles before the next start-of-packet are counted and checked. Every mismatch sets a sticky flag for its kind and adds to a saturating error counter. Once the programmed number of packets has ended, a done output rises. Any later start-of-packet is reported as an overrun.

Top module: `pkt_conf_chk`

## Requirements
- R1: Writes on the register port go to holding registers at these addresses: 0 packet count, 1 packet length, 2 header length, 3 stamp length, 4 burst size, 5 in-burst gap, 6 between-burst gap, 7 header word, 8 stamp word, 9 padding word. They take effect only at the next start, so a write made during a run has no effect on that run.
- R2: After reset, and in the cycle after start is sampled high, err_flags and err_count are zero. done is low after reset.
- R3: A word at position p, counted from 0 at start-of-packet, with p below the header length, must equal the header word. Otherwise err_flags bit 1 is set.
- R4: A word at a position from the header length up to, but not including, header length plus stamp length must equal the stamp word. Otherwise err_flags bit 2 is set.
- R5: Every later word of the packet must equal the padding word. Otherwise err_flags bit 3 is set.
- R6: The number of words from the start-of-packet word to the end-of-packet word, both included, must equal the packet length. Otherwise err_flags bit 0 is set when end-of-packet is seen.
- R7: The number of cycles strictly between an end-of-packet word and the next start-of-packet word must equal the between-burst gap after every burst-size-th packet, and the in-burst gap after any other packet. A burst size of 0 acts as 1. A mismatch sets err_flags bit 4.
- R8: done rises once the programmed number of end-of-packet words have been seen, and stays high until the next start. A packet count of 0 raises done straight after start.
- R9: A valid start-of-packet word seen while done is high sets err_flags bit 5 (overrun).
- R10: A valid start-of-packet inside a packet, or a valid word without start-of-packet between packets, sets err_flags bit 6 (framing).
- R11: Flags stay set until the next start. Each mismatch event adds one to err_count, with several events in one cycle adding their number, and err_count saturates at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| start | input | 1 | Load configuration, clear results, arm |
| s_valid | input | 1 | Stream word valid |
| s_sop | input | 1 | Start-of-packet marker |
| s_eop | input | 1 | End-of-packet marker |
| s_data | input | 32 | Stream data word |
| err_flags | output | 7 | Sticky mismatch flags, bit meanings in R3 to R10 |
| err_count | output | 16 | Saturating mismatch counter |
| done | output | 1 | Programmed packet count observed |

## Verification
The bench goes after the gap that follows the last packet of a burst. A checker that picked the wrong gap there would raise the gap flag on clean bursty traffic. It also covers zero header and stamp lengths, where a word at position 0 must be judged as stamp or padding rather than header, and a design that misplaced those boundaries would blame the wrong field. A zero packet count must give done at once, and a checker that waited for a packet would hang. One packet of more than 65,535 bad words checks that the counter sticks at all ones instead of wrapping. A configuration write in the middle of a run must leave that run alone; a design without the holding copy would flag clean traffic as header errors.

// File: rtl/pkt_conf_chk.sv
module pkt_conf_chk #(
  parameter int DW  = 32,
  parameter int CW  = 16,
  parameter int ECW = 16,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  input  logic           start,
  input  logic           s_valid,
  input  logic           s_sop,
  input  logic           s_eop,
  input  logic [DW-1:0]  s_data,
  output logic [6:0]     err_flags,
  output logic [ECW-1:0] err_count,
  output logic           done
);
  localparam int F_LEN = 0, F_HDR = 1, F_STP = 2, F_PAD = 3, F_GAP = 4, F_OVR = 5, F_FRM = 6;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_ARM, S_HDR, S_STP, S_PAD, S_GAP, S_END} st_t;
  st_t state;

  logic [CW-1:0] sh_cnt, sh_plen, sh_hlen, sh_slen, sh_bsz, sh_ipg, sh_ibg;
  logic [DW-1:0] sh_hdr, sh_stp, sh_pad;
  logic [CW-1:0] a_cnt, a_plen, a_hlen, a_slen, a_bsz, a_ipg, a_ibg;
  logic [DW-1:0] a_hdr, a_stp, a_pad;
  logic [CW-1:0] idx, pkts, bcnt, gap_cnt;
  logic          gap_burst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_cnt <= '0; sh_plen <= '0; sh_hlen <= '0; sh_slen <= '0;
      sh_bsz <= '0; sh_ipg <= '0; sh_ibg <= '0;
      sh_hdr <= '0; sh_stp <= '0; sh_pad <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        AW'(0): sh_cnt  <= cfg_wdata[CW-1:0];
        AW'(1): sh_plen <= cfg_wdata[CW-1:0];
        AW'(2): sh_hlen <= cfg_wdata[CW-1:0];
        AW'(3): sh_slen <= cfg_wdata[CW-1:0];
        AW'(4): sh_bsz  <= cfg_wdata[CW-1:0];
        AW'(5): sh_ipg  <= cfg_wdata[CW-1:0];
        AW'(6): sh_ibg  <= cfg_wdata[CW-1:0];
        AW'(7): sh_hdr  <= cfg_wdata;
        AW'(8): sh_stp  <= cfg_wdata;
        AW'(9): sh_pad  <= cfg_wdata;
        default: ;
      endcase
    end

  function automatic st_t ph(input logic [CW:0] i);
    if (i < {1'b0, a_hlen}) return S_HDR;
    if (i < ({1'b0, a_hlen} + {1'b0, a_slen})) return S_STP;
    return S_PAD;
  endfunction

  wire in_pkt  = (state == S_HDR) || (state == S_STP) || (state == S_PAD);
  wire waiting = (state == S_ARM) || (state == S_GAP);
  wire sop_acc = s_valid & s_sop & (in_pkt | waiting);
  wire take    = s_valid & (sop_acc | in_pkt);

  logic [CW:0]  cur_idx, nxt_idx;
  st_t          cur_ph;
  logic [6:0]   ev;
  logic [ECW:0] cnt_sum;

  assign cur_idx = sop_acc ? '0 : {1'b0, idx};
  assign nxt_idx = cur_idx + 1'b1;
  assign cur_ph  = ph(cur_idx);

  wire last_pkt  = ({1'b0, pkts} + 1'b1) == {1'b0, a_cnt};
  wire burst_end = ({1'b0, bcnt} + 1'b1) >= {1'b0, a_bsz};
  wire [CW-1:0] gap_exp = gap_burst ? a_ibg : a_ipg;

  always_comb begin
    ev = '0;
    ev[F_HDR] = take & (cur_ph == S_HDR) & (s_data != a_hdr);
    ev[F_STP] = take & (cur_ph == S_STP) & (s_data != a_stp);
    ev[F_PAD] = take & (cur_ph == S_PAD) & (s_data != a_pad);
    ev[F_LEN] = take & s_eop & (nxt_idx != {1'b0, a_plen});
    ev[F_GAP] = sop_acc & (state == S_GAP) & (gap_cnt != gap_exp);
    ev[F_OVR] = s_valid & s_sop & (state == S_END);
    ev[F_FRM] = s_valid & ((s_sop & in_pkt) | (!s_sop & waiting));
  end

  assign cnt_sum = {1'b0, err_count} + (ECW+1)'($countones(ev));
  assign done    = (state == S_END);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      err_flags <= '0; err_count <= '0;
      a_cnt <= '0; a_plen <= '0; a_hlen <= '0; a_slen <= '0;
      a_bsz <= '0; a_ipg <= '0; a_ibg <= '0;
      a_hdr <= '0; a_stp <= '0; a_pad <= '0;
      idx <= '0; pkts <= '0; bcnt <= '0; gap_cnt <= '0; gap_burst <= 1'b0;
    end else if (start) begin
      state <= S_LOAD;
      err_flags <= '0;
      err_count <= '0;
    end else begin
      err_flags <= err_flags | ev;
      err_count <= cnt_sum[ECW] ? '1 : cnt_sum[ECW-1:0];
      case (state)
        S_IDLE, S_END: ;
        S_LOAD: begin
          a_cnt <= sh_cnt; a_plen <= sh_plen; a_hlen <= sh_hlen; a_slen <= sh_slen;
          a_bsz <= sh_bsz; a_ipg <= sh_ipg; a_ibg <= sh_ibg;
          a_hdr <= sh_hdr; a_stp <= sh_stp; a_pad <= sh_pad;
          idx <= '0; pkts <= '0; bcnt <= '0; gap_cnt <= '0; gap_burst <= 1'b0;
          state <= (sh_cnt == '0) ? S_END : S_ARM;
        end
        default: begin
          if (take) begin
            if (s_eop) begin
              pkts      <= pkts + 1'b1;
              gap_cnt   <= '0;
              gap_burst <= burst_end;
              bcnt      <= burst_end ? '0 : bcnt + 1'b1;
              idx       <= '0;
              state     <= last_pkt ? S_END : S_GAP;
            end else begin
              idx   <= nxt_idx[CW] ? '1 : nxt_idx[CW-1:0];
              state <= ph(nxt_idx);
            end
          end else if (state == S_GAP && !(&gap_cnt)) begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
      endcase
    end
endmodule

module pkt_conf_chk_sva #(parameter int ECW = 16) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [6:0]     err_flags,
  input logic [ECW-1:0] err_count,
  input logic           done
);
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (err_flags == '0 && err_count == '0)); // R2
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ((err_flags & $past(err_flags)) == $past(err_flags))); // R11
  AST_COUNT_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (err_count >= $past(err_count))); // R11
  AST_NEW_FLAG_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (((err_flags & ~$past(err_flags)) == '0) || (err_count > $past(err_count))
                || (err_count == '1))); // R11
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R8
  AST_OVERRUN_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[5]) |-> $past(done)); // R9
endmodule

bind pkt_conf_chk pkt_conf_chk_sva #(.ECW(ECW)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start),
  .err_flags(err_flags), .err_count(err_count), .done(done)
);

// File: tb/sim_pkt_conf_chk.sv
module sim_pkt_conf_chk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        start = 1'b0;
  logic        s_valid = 1'b0, s_sop = 1'b0, s_eop = 1'b0;
  logic [31:0] s_data = '0;
  logic [6:0]  err_flags;
  logic [15:0] err_count;
  logic        done;

  int checks = 0;
  int fails  = 0;
  logic [6:0] exp_f;
  int         exp_n;

  always #10ns clk = ~clk;

  pkt_conf_chk u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .start(start), .s_valid(s_valid), .s_sop(s_sop), .s_eop(s_eop), .s_data(s_data),
    .err_flags(err_flags), .err_count(err_count), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a[3:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic put(input logic v, input logic sp, input logic ep, input logic [31:0] d);
    s_valid = v; s_sop = sp; s_eop = ep; s_data = d;
    @(negedge clk);
    s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b0, 1'b0, 1'b0, 32'h0);
  endtask

  function automatic int cls(input int j, input int h, input int s);
    if (j < h) return 1;
    if (j < h + s) return 2;
    return 3;
  endfunction

  function automatic int gap_for(input int k, input int bsz, input int ipg, input int ibg);
    int b = (bsz == 0) ? 1 : bsz;
    return (k % b == 0) ? ibg : ipg;
  endfunction

  task automatic configure(input int cnt, plen, h, s, bsz, ipg, ibg,
                           input logic [31:0] hw, sw, pw);
    wr(0, cnt); wr(1, plen); wr(2, h); wr(3, s); wr(4, bsz); wr(5, ipg); wr(6, ibg);
    wr(7, hw); wr(8, sw); wr(9, pw);
  endtask

  task automatic send_pkt(input int len, h, s, input logic [31:0] hw, sw, pw, input int bad);
    for (int j = 0; j < len; j++) begin
      int c = cls(j, h, s);
      logic [31:0] w = (c == 1) ? hw : (c == 2) ? sw : pw;
      if (j == bad) begin
        w = w ^ 32'h1;
        exp_f[c] = 1'b1;
        exp_n++;
      end
      put(1'b1, j == 0, j == len - 1, w);
    end
  endtask

  task automatic run_test(input string tag, input int cnt, plen, h, s, bsz, ipg, ibg,
                          input logic [31:0] hw, sw, pw, input int pct);
    configure(cnt, plen, h, s, bsz, ipg, ibg, hw, sw, pw);
    pulse_start();
    exp_f = '0; exp_n = 0;
    for (int k = 0; k < cnt; k++) begin
      int len = plen;
      int bad = -1;
      if (k > 0) begin
        int g = gap_for(k, bsz, ipg, ibg);
        int ga = g;
        if (int'($urandom_range(99)) < pct) ga = (g > 0) ? g - 1 : g + 1;
        if (ga != g) begin exp_f[4] = 1'b1; exp_n++; end
        idle(ga);
      end
      if (k == cnt - 1) chk({tag, " R8 done low before last packet"}, done, 0);
      if (int'($urandom_range(99)) < pct) len = (plen > 1) ? plen - 1 : plen + 1;
      if (len != plen) begin exp_f[0] = 1'b1; exp_n++; end
      if (int'($urandom_range(99)) < pct) bad = $urandom_range(len - 1);
      send_pkt(len, h, s, hw, sw, pw, bad);
    end
    idle(2);
    chk({tag, " R3 R4 R5 R6 R7 flags"}, err_flags, exp_f);
    chk({tag, " R11 count"}, err_count, exp_n);
    chk({tag, " R8 done"}, done, 1);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R8 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset flags", err_flags, 0);
    chk("R2 reset count", err_count, 0);
    chk("R2 reset done", done, 0);

    run_test("clean", 5, 6, 2, 2, 2, 3, 7, 32'hAAAA0001, 32'h5555_0002, 32'h0F0F_0003, 0);

    // R1: write during run ignored, then used at next start
    configure(2, 4, 1, 1, 1, 2, 2, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333);
    pulse_start();
    exp_f = '0; exp_n = 0;
    wr(7, 32'h9999_9999);
    send_pkt(4, 1, 1, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333, -1);
    idle(2);
    send_pkt(4, 1, 1, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333, -1);
    idle(2);
    chk("R1 mid-run write ignored", err_flags, 0);
    pulse_start();
    send_pkt(4, 1, 1, 32'h9999_9999, 32'h2222_2222, 32'h3333_3333, -1);
    idle(2);
    send_pkt(4, 1, 1, 32'h9999_9999, 32'h2222_2222, 32'h3333_3333, -1);
    idle(2);
    chk("R1 write applied at next start", err_flags, 0);
    chk("R8 done after R1 run", done, 1);

    // R9 overrun after done
    put(1'b1, 1'b1, 1'b0, 32'h0);
    idle(1);
    chk("R9 overrun flag", err_flags, 7'b010_0000);
    chk("R9 overrun count", err_count, 1);

    // R2 start clears
    pulse_start();
    chk("R2 start clears flags", err_flags, 0);
    chk("R2 start clears count", err_count, 0);

    // R8 zero packet count
    configure(0, 4, 1, 1, 1, 0, 0, 0, 0, 0);
    pulse_start();
    chk("R8 zero count done", done, 1);

    // R10 stray word between packets, and sop inside a packet
    configure(3, 3, 0, 0, 1, 1, 1, 0, 0, 32'h7);
    pulse_start();
    send_pkt(3, 0, 0, 0, 0, 32'h7, -1);
    put(1'b1, 1'b0, 1'b0, 32'h7);
    idle(1);
    chk("R10 stray word framing flag", err_flags, 7'b100_0000);
    configure(2, 3, 0, 0, 1, 0, 0, 0, 0, 32'h7);
    pulse_start();
    put(1'b1, 1'b1, 1'b0, 32'h7);
    put(1'b1, 1'b1, 1'b0, 32'h7);
    idle(1);
    chk("R10 nested sop framing flag", err_flags, 7'b100_0000);

    // R3 R4 R5 with zero header: word 0 is stamp
    run_test("nohdr", 2, 3, 0, 1, 1, 1, 1, 32'hDEAD, 32'h5A5A, 32'h0, 0);
    configure(1, 3, 0, 1, 1, 0, 0, 32'hDEAD, 32'h5A5A, 32'h0);
    pulse_start();
    exp_f = '0; exp_n = 0;
    send_pkt(3, 0, 1, 32'hDEAD, 32'h5A5A, 32'h0, 0);
    idle(1);
    chk("R4 stamp at position 0", err_flags, 7'b000_0100);

    // R11 saturation
    configure(1, 4, 0, 0, 1, 0, 0, 0, 0, 32'h0);
    pulse_start();
    for (int j = 0; j < 66000; j++) put(1'b1, j == 0, j == 65999, 32'hFFFF_FFFF);
    idle(1);
    chk("R11 counter saturates", err_count, 16'hFFFF);
    chk("R5 R6 saturation flags", err_flags, 7'b000_1001);

    for (int r = 0; r < 30; r++) begin
      int h = $urandom_range(3);
      int s = $urandom_range(3);
      int pl = h + s + $urandom_range(3);
      if (pl == 0) pl = 1;
      run_test($sformatf("rnd%0d", r), 1 + $urandom_range(5), pl, h, s, $urandom_range(3),
               $urandom_range(4), $urandom_range(6), $urandom, $urandom, $urandom,
               (r < 5) ? 0 : 20);
    end

    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule